// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host and an asynchronous 64K x 16 extended-data-out DRAM. The host hands it one word request at a time through a valid/ready handshake: a direction bit, a 16-bit word address, a two-bit lane enable and write data. The controller splits the address into an 8-bit row and an 8-bit column and drives them one after the other on a shared 8-bit address bus. It sequences the row strobe, the two per-lane column strobes, the write strobe and the output-enable strobe. Read data comes back as a single-cycle response pulse.

Once a row has been opened, it is left open. A later request to the same row goes straight to a column cycle with no new row activation. A request to a different row, a pending refresh request, or the approaching limit on row-strobe low time closes the row first. Every analog timing figure is a parameter counted in whole clock cycles. Refresh cycles are generated elsewhere. This block only hands over the DRAM pins through a request/grant pair, with all strobes parked high.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row (reqAddr[15:8]) is on dramAddr when dramRasN falls, and the column (reqAddr[7:0]) is on dramAddr when a column strobe falls.
- R2: Column strobe bit 0 (lower lane, data bits 7:0) falls only when reqByteEn[0] is set, and bit 1 (upper lane, bits 15:8) only when reqByteEn[1] is set. A write changes only the enabled lanes. A read returns zero in the disabled lanes.
- R3: Writes are early writes. dramWeN is low for at least one cycle before a column strobe falls, and dramDqOe is high whenever a column strobe is low with dramWeN low.
- R4: Between two low periods, dramRasN stays high for at least T_RP cycles.
- R5: A column strobe falls only while dramRasN is low, and at least T_RCD cycles after dramRasN fell.
- R6: A request to the open row is served without a new dramRasN fall. Between column cycles, all column strobes stay high for at least T_CP cycles.
- R7: A request to a different row first raises dramRasN and then opens the new row, giving exactly one new dramRasN fall.
- R8: dramRasN is never low for more than RAS_MAX consecutive cycles. This holds under back-to-back page hits and while the row sits open and idle.
- R9: A read response is a one-cycle rspValid pulse. Its data is sampled at least T_CAC+1 cycles after the column strobe fell, which relies on the extended data hold after the strobe rises.
- R10: While refReq is high, reqReady is low. An open row is closed, and once T_RP has elapsed refGnt is raised with dramRasN and both column strobes high. No row is opened until refReq drops. Refresh wins over a request that arrives in the same cycle.
- R11: During reset and in the first cycle after it, all strobes are high, dramDqOe, rspValid, refGnt and reqReady are low.
- R12: dramOeN is low only during reads, never together with a low dramWeN or a driven data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller accepts the request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address, row in the upper half, column in the lower half |
| reqByteEn | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | One-cycle read-data valid |
| rspData | output | 16 | Read data, disabled lanes zero |
| refReq | input | 1 | External refresh engine requests the DRAM pins |
| refGnt | output | 1 | Pins are parked and handed to the refresh engine |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 2 | Column strobes, bit 0 lower lane, bit 1 upper lane |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | 8 | Multiplexed row/column address |
| dramDqOut | output | 16 | Write data toward the DRAM |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 16 | Data from the DRAM |

## Verification
Two functions can fall in the same cycle: a refresh request and a host request that would be a page hit on the open row. The bench provokes this by raising refReq and presenting a same-row read on the same falling edge while the row is open and the column precharge has finished. It judges the outcome by three things. reqReady must stay low. refGnt must come up with all strobes high before the read is served. The read must then take a fresh row activation, seen as exactly one new dramRasN fall, and still return the stored word. A bus-level DRAM model presents filler data until T_CAC cycles after each column fall, so any early sample of the data is caught.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COLSET,
    ST_CAS,
    ST_OPEN,
    ST_GRANT
  } edoState_e;

  // strobes from control to datapath, all active high
  typedef struct packed {
    logic load;
    logic rasOn;
    logic casOn;
    logic weOn;
    logic oeOn;
    logic drive;
    logic useRow;
    logic capture;
  } edoStrobe_t;

endpackage

// File: rtl/edo_ctl.sv
`timescale 1ns/1ps
module edo_ctl
  import edo_pkg::*;
#(
  parameter int T_RP    = 3,
  parameter int T_RCD   = 1,
  parameter int T_CAS   = 1,
  parameter int T_CP    = 1,
  parameter int T_CAC   = 2,
  parameter int RAS_MAX = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rowHit,
  input  logic       refReq,
  output logic       reqReady,
  output logic       refGnt,
  output edoStrobe_t stb
);

  localparam int L_RD      = (T_CAS > T_CAC + 1) ? T_CAS : T_CAC + 1;
  localparam int L_WR      = T_CAS;
  localparam int GUARD     = L_RD + T_CP + 1;
  localparam int RAS_LIMIT = RAS_MAX - GUARD;
  localparam int SPAN      = T_RP + T_RCD + L_RD + T_CP;
  localparam int CNT_W     = $clog2(SPAN + 1);
  localparam int RAS_W     = $clog2(RAS_MAX + 1);

  edoState_e        state;
  logic [CNT_W-1:0] waitCnt;
  logic [RAS_W-1:0] rasCnt;
  logic             curWrite;
  logic             waitDone;
  logic             rasAged;
  logic             idleGo;
  logic             hitGo;
  logic             accept;

  assign waitDone = (waitCnt == '0);
  assign rasAged  = (rasCnt >= RAS_W'(RAS_LIMIT));
  assign idleGo   = (state == ST_IDLE) && waitDone && !refReq;
  assign hitGo    = (state == ST_OPEN) && waitDone && !refReq && !rasAged && rowHit;
  assign reqReady = idleGo || hitGo;
  assign accept   = reqReady && reqValid;
  assign refGnt   = (state == ST_GRANT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= CNT_W'(T_RP - 1);
      curWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!waitDone) waitCnt <= waitCnt - 1'b1;
          else if (refReq) state <= ST_GRANT;
          else if (reqValid) begin
            state    <= ST_ROW;
            waitCnt  <= CNT_W'(T_RCD - 1);
            curWrite <= reqWrite;
          end
        end
        ST_ROW: begin
          if (!waitDone) waitCnt <= waitCnt - 1'b1;
          else state <= ST_COLSET;
        end
        ST_COLSET: begin
          state   <= ST_CAS;
          waitCnt <= curWrite ? CNT_W'(L_WR - 1) : CNT_W'(L_RD - 1);
        end
        ST_CAS: begin
          if (!waitDone) waitCnt <= waitCnt - 1'b1;
          else begin
            state   <= ST_OPEN;
            waitCnt <= CNT_W'(T_CP - 1);
          end
        end
        ST_OPEN: begin
          if (!waitDone) waitCnt <= waitCnt - 1'b1;
          else if (refReq || rasAged || (reqValid && !rowHit)) begin
            state   <= ST_IDLE;
            waitCnt <= CNT_W'(T_RP - 1);
          end else if (reqValid) begin
            state    <= ST_COLSET;
            curWrite <= reqWrite;
          end
        end
        ST_GRANT: begin
          if (!refReq) begin
            state   <= ST_IDLE;
            waitCnt <= CNT_W'(T_RP - 1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycles the row strobe has been requested low
  always_ff @(posedge clk) begin
    if (!rstN) rasCnt <= '0;
    else if (state == ST_IDLE || state == ST_GRANT) rasCnt <= '0;
    else if (rasCnt != RAS_W'(RAS_MAX)) rasCnt <= rasCnt + 1'b1;
  end

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.rasOn   = (state == ST_ROW) || (state == ST_COLSET) ||
                  (state == ST_CAS) || (state == ST_OPEN);
    stb.casOn   = (state == ST_CAS);
    stb.weOn    = curWrite && ((state == ST_COLSET) || (state == ST_CAS) || (state == ST_OPEN));
    stb.oeOn    = !curWrite && ((state == ST_COLSET) || (state == ST_CAS));
    stb.drive   = stb.weOn;
    stb.useRow  = (state == ST_ROW);
    stb.capture = (state == ST_CAS) && waitDone && !curWrite;
  end

  // R10: a grant is never entered straight from an open row
  assert_gnt_from_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refGnt) |-> $past(state) == ST_IDLE);

endmodule

// File: rtl/edo_dp.sv
`timescale 1ns/1ps
module edo_dp
  import edo_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  edoStrobe_t               stb,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [LANES-1:0]         reqByteEn,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        dramDqIn,
  output logic                     rowHit,
  output logic                     dramRasN,
  output logic [LANES-1:0]         dramCasN,
  output logic                     dramWeN,
  output logic                     dramOeN,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]        dramDqOut,
  output logic                     dramDqOe,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] latAddr;
  logic [LANES-1:0]  latBe;
  logic [DATA_W-1:0] latData;
  logic              capQ;
  logic [LANES-1:0]  capBe;
  logic [DATA_W-1:0] laneMask;
  logic [BUS_W-1:0]  rowBus;
  logic [BUS_W-1:0]  colBus;

  assign rowHit = (reqAddr[ADDR_W-1:COL_W] == latAddr[ADDR_W-1:COL_W]);
  assign rowBus = BUS_W'(latAddr[ADDR_W-1:COL_W]);
  assign colBus = BUS_W'(latAddr[COL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr <= '0;
      latBe   <= '0;
      latData <= '0;
    end else if (stb.load) begin
      latAddr <= reqAddr;
      latBe   <= reqByteEn;
      latData <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramRasN  <= 1'b1;
      dramWeN   <= 1'b1;
      dramOeN   <= 1'b1;
      dramDqOe  <= 1'b0;
      dramAddr  <= '0;
      dramDqOut <= '0;
    end else begin
      dramRasN  <= !stb.rasOn;
      dramWeN   <= !stb.weOn;
      dramOeN   <= !stb.oeOn;
      dramDqOe  <= stb.drive;
      dramAddr  <= stb.useRow ? rowBus : colBus;
      dramDqOut <= latData;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) dramCasN[i] <= 1'b1;
      else       dramCasN[i] <= !(stb.casOn && latBe[i]);
    end
    assign laneMask[i*LANE_W +: LANE_W] = {LANE_W{capBe[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ     <= 1'b0;
      capBe    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      capQ     <= stb.capture;
      capBe    <= latBe;
      rspValid <= capQ;
      if (capQ) rspData <= dramDqIn & laneMask;
    end
  end

  // R12: output enable and write strobe never low together
  assert_oe_vs_we_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dramOeN |-> (dramWeN && !dramDqOe));

  // R9: response is a single-cycle pulse
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int T_RP    = 3,
  parameter int T_RCD   = 1,
  parameter int T_CAS   = 1,
  parameter int T_CP    = 1,
  parameter int T_CAC   = 2,
  parameter int RAS_MAX = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [1:0]  reqByteEn,
  input  logic [15:0] reqWdata,
  output logic        rspValid,
  output logic [15:0] rspData,
  input  logic        refReq,
  output logic        refGnt,
  output logic        dramRasN,
  output logic [1:0]  dramCasN,
  output logic        dramWeN,
  output logic        dramOeN,
  output logic [7:0]  dramAddr,
  output logic [15:0] dramDqOut,
  output logic        dramDqOe,
  input  logic [15:0] dramDqIn
);

  localparam int RAS_W = $clog2(RAS_MAX + 2);

  edoStrobe_t stb;
  logic       rowHit;

  edo_ctl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_CAC(T_CAC), .RAS_MAX(RAS_MAX)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .refReq(refReq), .reqReady(reqReady),
    .refGnt(refGnt), .stb(stb)
  );

  edo_dp #(.ROW_W(8), .COL_W(8), .DATA_W(16), .LANES(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqWdata(reqWdata), .dramDqIn(dramDqIn),
    .rowHit(rowHit), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

  // pin-level watch of row strobe low time
  logic [RAS_W-1:0] rasLowCnt;
  logic             casAny;
  assign casAny = ~&dramCasN;

  always_ff @(posedge clk) begin
    if (!rstN || dramRasN) rasLowCnt <= '0;
    else if (rasLowCnt != RAS_W'(RAS_MAX + 1)) rasLowCnt <= rasLowCnt + 1'b1;
  end

  assert_ras_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    rasLowCnt <= RAS_W'(RAS_MAX));

  assert_cas_in_row_R5: assert property (@(posedge clk) disable iff (!rstN)
    casAny |-> !dramRasN);

  assert_early_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(casAny) && !dramWeN) |-> $past(!dramWeN));

  assert_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (casAny && !dramWeN) |-> dramDqOe);

  assert_gnt_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    refGnt |-> (dramRasN && !casAny));

endmodule

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

  localparam int T_RP = 2, T_RCD = 2, T_CAS = 1, T_CP = 1, T_CAC = 2, RAS_MAX = 30;
  localparam logic [15:0] GARB = 16'hA5A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic        reqReady, rspValid, refGnt, dramRasN, dramWeN, dramOeN, dramDqOe;
  logic [15:0] rspData, dramDqOut;
  logic [15:0] dramDqIn = GARB;
  logic [1:0]  dramCasN;
  logic [7:0]  dramAddr;

  always #5 clk = ~clk;

  edo_page_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                  .T_CAC(T_CAC), .RAS_MAX(RAS_MAX)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqByteEn(reqByteEn),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .refReq(refReq), .refGnt(refGnt), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- DRAM model (rows 0..3 only) ----------------
  logic [15:0] mem    [1024];
  logic [15:0] shadow [1024];
  logic [7:0]  expRow = '0, expCol = '0;
  logic [1:0]  expBe = 2'b11;
  int          rasFalls = 0;

  logic       prevRas = 1'b1;
  logic [1:0] prevCas = 2'b11;
  logic [7:0] curRow = '0;
  logic [9:0] rdIdx = '0;
  logic [1:0] rdLanes = '0;
  int rasHighCnt = 0, rasLowCnt = 0, casHighCnt = 0, sinceRas = 0, age = 0;
  bit firstCas = 1'b0, pending = 1'b0;

  always begin
    @(posedge clk);
    #2;
    if (rstN) begin
      if (prevRas && !dramRasN) begin
        chk(rasHighCnt >= T_RP, "R4 row precharge", rasHighCnt, T_RP);
        chk(dramAddr == expRow, "R1 row address", dramAddr, expRow);
        curRow = dramAddr; sinceRas = 0; firstCas = 1'b1; rasFalls++;
      end
      if (!prevRas && dramRasN)
        chk(rasLowCnt <= RAS_MAX, "R8 row low time", rasLowCnt, RAS_MAX);
      if ((|(prevCas & ~dramCasN)) && !dramRasN) begin
        if (firstCas) chk(sinceRas >= T_RCD, "R5 row to column delay", sinceRas, T_RCD);
        else          chk(casHighCnt >= T_CP, "R6 column precharge", casHighCnt, T_CP);
        firstCas = 1'b0;
        chk(dramAddr == expCol, "R1 column address", dramAddr, expCol);
        chk(dramCasN == ~expBe, "R2 lane strobes", dramCasN, ~expBe);
        if (!dramWeN) begin
          chk(dramDqOe, "R3 data driven in write", dramDqOe, 1);
          for (int i = 0; i < 2; i++)
            if (!dramCasN[i]) mem[{curRow[1:0], dramAddr}][i*8 +: 8] = dramDqOut[i*8 +: 8];
        end else begin
          pending = 1'b1; age = 0; rdIdx = {curRow[1:0], dramAddr};
          rdLanes = ~dramCasN; dramDqIn = GARB;
        end
      end else if (pending) begin
        age++;
        if (age == T_CAC) begin
          for (int i = 0; i < 2; i++)
            dramDqIn[i*8 +: 8] = (rdLanes[i] && !dramOeN) ? mem[rdIdx][i*8 +: 8] : GARB[i*8 +: 8];
        end
      end
      if (dramRasN && &dramCasN) begin
        pending = 1'b0; dramDqIn = GARB;
      end
    end
    rasHighCnt = dramRasN ? rasHighCnt + 1 : 0;
    rasLowCnt  = dramRasN ? 0 : rasLowCnt + 1;
    casHighCnt = (&dramCasN) ? casHighCnt + 1 : 0;
    sinceRas++;
    prevRas = dramRasN; prevCas = dramCasN;
  end

  // ---------------- host side ----------------
  function automatic logic [15:0] laneMask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] dataOf(input int r, input int k);
    return 16'(r * 16'h1357 + k * 16'h0B0D + 16'h2468);
  endfunction

  task automatic finishReq(input bit wr, input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    int n = 0;
    #1;
    while (!reqReady && n < 300) begin @(negedge clk); #1; n++; end
    chk(reqReady, "R10 request eventually accepted", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    expRow = a[15:8]; expCol = a[7:0]; expBe = be;
    if (wr) shadow[{a[9:8], a[7:0]}] = (shadow[{a[9:8], a[7:0]}] & ~laneMask(be)) | (d & laneMask(be));
  endtask

  task automatic present(input bit wr, input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqByteEn = be; reqWdata = d;
  endtask

  task automatic issue(input bit wr, input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    present(wr, a, be, d);
    finishReq(wr, a, be, d);
  endtask

  task automatic waitRsp(input logic [15:0] a, input logic [1:0] be, input string req);
    int n = 0;
    logic [15:0] e;
    e = shadow[{a[9:8], a[7:0]}] & laneMask(be);
    while (!rspValid && n < 60) begin @(negedge clk); n++; end
    chk(rspValid, {req, " response arrives"}, rspValid, 1);
    chk(rspData == e, {req, " read data"}, rspData, e);
    @(negedge clk);
    chk(!rspValid, "R9 one-cycle response", rspValid, 0);
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] be, input string req);
    issue(1'b0, a, be, 16'h0);
    waitRsp(a, be, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; shadow[i] = '0; end

    // R11 reset state
    repeat (4) @(negedge clk);
    chk(dramRasN && &dramCasN && dramWeN && dramOeN, "R11 strobes high in reset",
        {dramRasN, dramCasN, dramWeN, dramOeN}, 5'h1f);
    chk(!dramDqOe && !rspValid && !refGnt && !reqReady, "R11 outputs low in reset",
        {dramDqOe, rspValid, refGnt, reqReady}, 0);
    rstN = 1'b1;
    #1;
    chk(!reqReady && dramRasN, "R11 first cycle after reset", {reqReady, dramRasN}, 1);

    // R1 R6 R8 R9: word sweep with long page-hit runs
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 12; k++)
        issue(1'b1, {8'(r), 8'(k * 23)}, 2'b11, dataOf(r, k));
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 12; k++)
        rd({8'(r), 8'(k * 23)}, 2'b11, "R1 sweep");

    // R2 byte lanes
    issue(1'b1, 16'h0205, 2'b11, 16'h1234);
    issue(1'b1, 16'h0205, 2'b01, 16'h77AB);
    issue(1'b1, 16'h0205, 2'b10, 16'hCD66);
    rd(16'h0205, 2'b11, "R2 merged word");
    chk(rspData == 16'hCDAB, "R2 lane merge value", rspData, 16'hCDAB);
    rd(16'h0205, 2'b01, "R2 lower-lane read");
    rd(16'h0205, 2'b10, "R2 upper-lane read");

    // R6 page hits, R7 page miss
    rd(16'h0311, 2'b11, "R7 miss");
    base = rasFalls;
    rd(16'h0100, 2'b11, "R7 new row");
    rd(16'h0117, 2'b11, "R6 hit");
    rd(16'h012E, 2'b11, "R6 hit");
    chk(rasFalls - base == 1, "R6 no reopen on hits", rasFalls - base, 1);
    base = rasFalls;
    rd(16'h0000, 2'b11, "R7 miss");
    chk(rasFalls - base == 1, "R7 single reopen", rasFalls - base, 1);

    // R10 refresh handover with a waiting request
    rd(16'h0145, 2'b11, "R10 before refresh");
    @(negedge clk);
    refReq = 1'b1;
    present(1'b0, 16'h0145, 2'b11, 16'h0);
    base = rasFalls;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      chk(!reqReady, "R10 no accept during refresh", reqReady, 0);
    end
    chk(refGnt && dramRasN && &dramCasN, "R10 grant with strobes high",
        {refGnt, dramRasN, dramCasN}, 4'hf);
    chk(rasFalls == base, "R10 no row during grant", rasFalls - base, 0);
    refReq = 1'b0;
    finishReq(1'b0, 16'h0145, 2'b11, 16'h0);
    chk(!refGnt, "R10 grant released", refGnt, 0);
    waitRsp(16'h0145, 2'b11, "R10 after refresh");

    // collision: refresh and a page hit in the same cycle
    rd(16'h0162, 2'b11, "R10 open row");
    repeat (2) @(negedge clk);
    base = rasFalls;
    refReq = 1'b1;
    present(1'b0, 16'h0179, 2'b11, 16'h0);
    #1;
    chk(!reqReady, "R10 refresh beats page hit", reqReady, 0);
    begin
      int n = 0;
      while (!refGnt && n < 40) begin @(negedge clk); n++; end
    end
    chk(refGnt, "R10 grant after collision", refGnt, 1);
    refReq = 1'b0;
    finishReq(1'b0, 16'h0179, 2'b11, 16'h0);
    waitRsp(16'h0179, 2'b11, "R10 collision read");
    chk(rasFalls - base == 1, "R10 row reopened after refresh", rasFalls - base, 1);

    // R8 idle open row is closed by the timer
    rd(16'h0200, 2'b11, "R8 open then idle");
    repeat (RAS_MAX + 10) @(negedge clk);
    chk(dramRasN, "R8 idle row closed", dramRasN, 1);

    // R12 output enable never low during a write
    issue(1'b1, 16'h0301, 2'b11, 16'h5A5A);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk(dramOeN, "R12 no output enable in write", dramOeN, 1);
    end
    rd(16'h0301, 2'b11, "R3 early write readback");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule